// File: doc/BRIEF.md
# Host Register Access Front End

This block sits between a host processor bus and the register set of a serial communications peripheral. It decodes a three-line chip select, where two lines are active high and one is active low. It accepts read and write strobes in either polarity, and it can hold the register address and the select state through an address strobe. That strobe is needed on buses that put address and data on the same wires. From the bus activity it produces a read enable with a read address and a one-cycle write commit pulse with its address and data. It also drives a drive-disable output for external bus transceivers.

The same block drives two active-low status pins from occupancy counts. One reports that received characters are waiting. The other reports that the transmit queue still has room. The tristate data bus is split into an input port, an output port and an output enable. All inputs are taken to be synchronous to `clk`, and reset is synchronous and active high.

Top module: `uart_host_port`

## Requirements
- R1: The device counts as selected only when `cs0`=1, `cs1`=1 and `cs2_n`=0 hold together. With any other combination there is no read enable, no output enable and no write commit.
- R2: While `as_n` is 0, the address path is transparent: the live `cs0`/`cs1`/`cs2_n` decode and the live `addr` are used in the same cycle.
- R3: While `as_n` is 1, the select state and address are those sampled in the last clock cycle before `as_n` rose. Changes on `addr` and the chip selects have no effect until `as_n` returns to 0.
- R4: A read is active when `ior`=1 or `ior_n`=0. `reg_re` is 1 exactly while the device is selected and a read is active, and in that case `reg_raddr` equals the effective address.
- R5: `dout_oe` is 1 exactly when `reg_re` is 1, and `dout` then equals `reg_rdata`. Otherwise `dout` is all zeros.
- R6: `ddis_n` is 0 only during a selected read, and it is the inverse of `dout_oe`.
- R7: A write is active when `iow`=1 or `iow_n`=0. After an active phase during which the device was selected, `reg_we` is 1 for exactly one cycle: the first cycle in which the write strobe is seen inactive. `reg_waddr` and `reg_wdata` carry the effective address and `din` from the last selected cycle of that phase, with `din` bit 0 mapped to `reg_wdata` bit 0.
- R8: A write phase in which the device is never selected produces no `reg_we`.
- R9: `rxrdy_n` is 0 when `rx_count` is nonzero and 1 when `rx_count` is 0.
- R10: `txrdy_n` is 0 when `tx_count` is below the queue depth (16) and 1 when `tx_count` equals the depth.
- R11: Reset clears the held select state, the held address and any pending write. After reset, with `as_n` high and no new sample taken, the device is unselected and no commit occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe; a rise freezes select and address |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| addr | input | 3 | Register address |
| ior | input | 1 | Read strobe, active high |
| ior_n | input | 1 | Read strobe, active low |
| iow | input | 1 | Write strobe, active high |
| iow_n | input | 1 | Write strobe, active low |
| din | input | 8 | Data from host, bit 0 least significant |
| dout | output | 8 | Data to host |
| dout_oe | output | 1 | Data bus drive enable |
| ddis_n | output | 1 | Transceiver drive disable, low during selected read |
| reg_re | output | 1 | Register read enable |
| reg_raddr | output | 3 | Register read address |
| reg_rdata | input | 8 | Read data from the register file |
| reg_we | output | 1 | One-cycle write commit |
| reg_waddr | output | 3 | Write commit address |
| reg_wdata | output | 8 | Write commit data |
| rx_count | input | 5 | Receive queue occupancy |
| tx_count | input | 5 | Transmit queue occupancy |
| rxrdy_n | output | 1 | Receive data waiting, active low |
| txrdy_n | output | 1 | Transmit room available, active low |

## Verification
The bench targets the address strobe freeze. It changes the address and deselects the device while `as_n` is high: a transparent latch would switch registers in the middle of an access, and an edge capture one cycle late would hold the wrong address. Long write strobes are used to catch a commit that fires at the start of the strobe or fires again on every cycle. Writes that were never selected are used to catch a commit that fires anyway. Occupancy counts of 0, 1, 15 and 16 expose off-by-one errors on the ready pins. Mixed polarities on the strobe pairs expose a decoder that honours only one polarity.

// File: rtl/uhp_pkg.sv
package uhp_pkg;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FIFO_DEPTH = 16;
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);
endpackage

// File: rtl/uhp_sel_latch.sv
module uhp_sel_latch #(
    parameter int unsigned AW = uhp_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_n,
    input  logic          cs0,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic [AW-1:0] addr,
    output logic          sel_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic          sel;
        logic [AW-1:0] addr;
    } hold_t;

    hold_t st_d, st_q;
    logic  live_sel;

    assign live_sel = cs0 & cs1 & ~cs2_n;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!as_n) begin
            st_d.sel  = live_sel;
            st_d.addr = addr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_o  = as_n ? st_q.sel  : live_sel;
    assign addr_o = as_n ? st_q.addr : addr;

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (as_n && $past(as_n)) |-> ($stable(sel_o) && $stable(addr_o))); // R3
endmodule

// File: rtl/uhp_strobe.sv
module uhp_strobe #(
    parameter int unsigned AW = uhp_pkg::ADDR_W,
    parameter int unsigned DW = uhp_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          ior,
    input  logic          ior_n,
    input  logic          iow,
    input  logic          iow_n,
    output logic          rd_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o
);
    typedef struct packed {
        logic          busy;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
    } wr_t;

    wr_t  st_d, st_q;
    logic rd_act, wr_act;

    assign rd_act = ior | ~ior_n;
    assign wr_act = iow | ~iow_n;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.busy = wr_act & (st_q.busy | sel);
            if (wr_act && sel) begin
                st_d.waddr = addr;
                st_d.wdata = din;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_o    = sel & rd_act;
    assign we_o    = st_q.busy & ~wr_act;
    assign waddr_o = st_q.waddr;
    assign wdata_o = st_q.wdata;

    AST_COMMIT_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        we_o |-> ($past(iow) || !$past(iow_n))); // R7
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        we_o |=> !we_o); // R7
endmodule

// File: rtl/uhp_ready.sv
module uhp_ready #(
    parameter int unsigned DEPTH = uhp_pkg::FIFO_DEPTH,
    parameter int unsigned CW    = uhp_pkg::CNT_W
) (
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rxrdy_n,
    output logic          txrdy_n
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    always_comb begin
        rxrdy_n = (rx_count == '0);
        txrdy_n = (tx_count >= FULL_LVL);
    end
endmodule

// File: rtl/uart_host_port.sv
module uart_host_port #(
    parameter int unsigned AW    = uhp_pkg::ADDR_W,
    parameter int unsigned DW    = uhp_pkg::DATA_W,
    parameter int unsigned DEPTH = uhp_pkg::FIFO_DEPTH,
    parameter int unsigned CW    = uhp_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_n,
    input  logic          cs0,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic [AW-1:0] addr,
    input  logic          ior,
    input  logic          ior_n,
    input  logic          iow,
    input  logic          iow_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          ddis_n,
    output logic          reg_re,
    output logic [AW-1:0] reg_raddr,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_we,
    output logic [AW-1:0] reg_waddr,
    output logic [DW-1:0] reg_wdata,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    output logic          rxrdy_n,
    output logic          txrdy_n
);
    logic          eff_sel;
    logic [AW-1:0] eff_addr;
    logic          rd_en;

    uhp_sel_latch #(.AW(AW)) u_latch (
        .clk(clk), .rst(rst), .as_n(as_n),
        .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n), .addr(addr),
        .sel_o(eff_sel), .addr_o(eff_addr)
    );

    uhp_strobe #(.AW(AW), .DW(DW)) u_strobe (
        .clk(clk), .rst(rst), .sel(eff_sel), .addr(eff_addr), .din(din),
        .ior(ior), .ior_n(ior_n), .iow(iow), .iow_n(iow_n),
        .rd_o(rd_en), .we_o(reg_we), .waddr_o(reg_waddr), .wdata_o(reg_wdata)
    );

    uhp_ready #(.DEPTH(DEPTH), .CW(CW)) u_ready (
        .rx_count(rx_count), .tx_count(tx_count),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    assign reg_re    = rd_en;
    assign reg_raddr = eff_addr;
    assign dout_oe   = rd_en;
    assign ddis_n    = ~rd_en;
    assign dout      = rd_en ? reg_rdata : '0;

    AST_DRIVE_DISABLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        dout_oe != ddis_n); // R6
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0)); // R5
endmodule

// File: tb/uart_host_port_test.sv
module uart_host_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst, as_n, cs0, cs1, cs2_n, ior, ior_n, iow, iow_n;
    logic [2:0] addr;
    logic [7:0] din, reg_rdata;
    logic [4:0] rx_count, tx_count;
    logic [7:0] dout, reg_wdata;
    logic [2:0] reg_raddr, reg_waddr;
    logic dout_oe, ddis_n, reg_re, reg_we, rxrdy_n, txrdy_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit       m_hsel, m_busy;
    bit [2:0] m_haddr, m_wa;
    bit [7:0] m_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_host_port uut (
        .clk(clk), .rst(rst), .as_n(as_n), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n),
        .addr(addr), .ior(ior), .ior_n(ior_n), .iow(iow), .iow_n(iow_n),
        .din(din), .dout(dout), .dout_oe(dout_oe), .ddis_n(ddis_n),
        .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .rx_count(rx_count), .tx_count(tx_count),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit live_sel(input bit c0, input bit c1, input bit c2n);
        return c0 && c1 && !c2n;
    endfunction

    // drive one cycle, check outputs against the model, then advance the model
    task automatic cyc(input bit r, input bit asn, input bit c0, input bit c1, input bit c2n,
                       input bit [2:0] a, input bit rd_h, input bit rd_l, input bit wr_h,
                       input bit wr_l, input bit [7:0] d, input bit [7:0] rdat,
                       input bit [4:0] rxc, input bit [4:0] txc);
        bit esel, erd, ewr, ewe;
        bit [2:0] ea;
        @(negedge clk);
        rst = r; as_n = asn; cs0 = c0; cs1 = c1; cs2_n = c2n; addr = a;
        ior = rd_h; ior_n = rd_l; iow = wr_h; iow_n = wr_l; din = d;
        reg_rdata = rdat; rx_count = rxc; tx_count = txc;
        #1;
        esel = asn ? m_hsel : live_sel(c0, c1, c2n);
        ea   = asn ? m_haddr : a;
        erd  = esel && (rd_h || !rd_l);
        ewr  = wr_h || !wr_l;
        ewe  = m_busy && !ewr;
        if (!r) begin
            chk("R4 reg_re", reg_re, erd);
            if (erd) chk("R4 reg_raddr", reg_raddr, ea);
            chk("R5 dout_oe", dout_oe, erd);
            chk("R5 dout", dout, erd ? rdat : 8'h00);
            chk("R6 ddis_n", ddis_n, !erd);
            chk("R7 reg_we", reg_we, ewe);
            if (ewe) begin
                chk("R7 reg_waddr", reg_waddr, m_wa);
                chk("R7 reg_wdata", reg_wdata, m_wd);
            end
            chk("R9 rxrdy_n", rxrdy_n, rxc == 0);
            chk("R10 txrdy_n", txrdy_n, txc >= DEPTH);
        end
        if (r) begin
            m_hsel = 0; m_haddr = 0; m_busy = 0; m_wa = 0; m_wd = 0;
        end else begin
            if (!asn) begin m_hsel = live_sel(c0, c1, c2n); m_haddr = a; end
            if (ewr && esel) begin m_wa = ea; m_wd = d; end
            m_busy = ewr && (m_busy || esel);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) cyc(1, 1, 1, 1, 0, 3'd7, 0, 1, 0, 1, 8'h00, 8'h00, 0, 0);
        // R11: after reset with as_n high the device is unselected
        cyc(0, 1, 1, 1, 0, 3'd6, 1, 1, 0, 1, 8'h11, 8'hA5, 0, 0);
        chk("R11 no select after reset", reg_re, 0);
        chk("R11 no commit after reset", reg_we, 0);

        // R1: every non-selecting chip select combination
        for (int k = 0; k < 8; k++) begin
            cyc(0, 0, k[0], k[1], k[2], 3'd2, 0, 0, 0, 1, 8'h00, 8'h3C, 1, 0);
            chk("R1 decode", reg_re, (k == 3) ? 1 : 0);
        end

        // R2: transparent with as_n low
        cyc(0, 0, 1, 1, 0, 3'd5, 1, 1, 0, 1, 8'h00, 8'h77, 0, 0);
        chk("R2 live address", reg_raddr, 3'd5);

        // R3: rise of as_n freezes addr 5, selected; later changes ignored
        cyc(0, 1, 0, 0, 1, 3'd2, 0, 0, 0, 1, 8'h00, 8'h42, 0, 0);
        chk("R3 held select", reg_re, 1);
        chk("R3 held address", reg_raddr, 3'd5);
        cyc(0, 1, 1, 0, 1, 3'd1, 1, 1, 0, 1, 8'h00, 8'h43, 0, 0);
        chk("R3 held address later", reg_raddr, 3'd5);

        // R7: long write via active-low strobe, held address 5
        cyc(0, 1, 0, 0, 0, 3'd0, 0, 1, 0, 0, 8'h81, 8'h00, 0, 0);
        cyc(0, 1, 0, 0, 0, 3'd0, 0, 1, 0, 0, 8'h82, 8'h00, 0, 0);
        cyc(0, 1, 0, 0, 0, 3'd0, 0, 1, 1, 1, 8'hC3, 8'h00, 0, 0);
        chk("R7 no early commit", reg_we, 0);
        cyc(0, 1, 0, 0, 0, 3'd0, 0, 1, 0, 1, 8'h00, 8'h00, 0, 0);
        chk("R7 commit", reg_we, 1);
        chk("R7 data bit order", reg_wdata, 8'hC3);
        cyc(0, 1, 0, 0, 0, 3'd0, 0, 1, 0, 1, 8'h00, 8'h00, 0, 0);
        chk("R7 single pulse", reg_we, 0);

        // R8: write never selected
        cyc(0, 0, 1, 0, 0, 3'd3, 0, 1, 1, 1, 8'h55, 8'h00, 0, 0);
        cyc(0, 0, 1, 0, 0, 3'd3, 0, 1, 1, 1, 8'h55, 8'h00, 0, 0);
        cyc(0, 0, 1, 0, 0, 3'd3, 0, 1, 0, 1, 8'h55, 8'h00, 0, 0);
        chk("R8 no commit unselected", reg_we, 0);

        // R9/R10 boundaries
        cyc(0, 0, 0, 0, 1, 3'd0, 0, 1, 0, 1, 8'h00, 8'h00, 1, 15);
        chk("R9 one waiting", rxrdy_n, 0);
        chk("R10 one free", txrdy_n, 0);
        cyc(0, 0, 0, 0, 1, 3'd0, 0, 1, 0, 1, 8'h00, 8'h00, 16, 16);
        chk("R10 full", txrdy_n, 1);
        chk("R9 full rx", rxrdy_n, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] r0 = $urandom;
            bit [31:0] r1 = $urandom;
            cyc((r0[9:0] == 0), r0[1] & r0[2], r0[3] | r0[4], r0[5] | r0[6], r0[7] & r0[8],
                r0[12:10], r0[13] & r0[14] & r0[15], ~(r0[16] & r0[17] & r0[18]),
                r0[19] & r0[20], ~(r0[21] & r0[22]),
                r1[7:0], r1[15:8], 5'(r1[20:16] % 17), 5'(r1[28:24] % 17));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule